// File: doc/BRIEF.md
# Playback Format Decoder with DMA Request Control

This block sits next to a codec's register file and turns an accepted 8-bit playback format value into the settings that the sample path needs. Those settings are a sample-rate select, a mono or stereo flag, the sample encoding, which companding expander to use, the byte order, and the log2 of the number of bytes in one frame. A mode input sets how many bits of the format value carry the encoding code.

The same block holds or drops the DMA request. It holds the request while playback is enabled and the last format was legal. It drops the request when playback is disabled or when a rejected format arrives. When the request is first held, a one-cycle pulse tells the transfer counter to clear. A rejected format leaves the previous settings in place and raises an error flag. The flag stays raised until a legal format is accepted.

Top module: `pbfmt_dreq_ctrl`

## Requirements
- R1: After reset, every output is zero. The reset settings are rate select 0, mono, unsigned 8-bit, no expander and little-endian, with frame shift 0, no error, no DMA hold and no clear pulse.
- R2: Decoded outputs change only in the cycle after a strobe (`fmt_valid` high) that carries a legal format. They hold their value in all other cycles.
- R3: `rate_sel` takes `fmt_value[3:0]`, where bit 0 picks the crystal and bits 3:1 pick the rate index. Crystal 0 with index 4 or index 5 is illegal, so `fmt_value[3:0]` equal to 8 or 10 is illegal.
- R4: `stereo` takes `fmt_value[4]` (1 = two channels).
- R5: The encoding code is `fmt_value[7:5]` when `mode_ext` is 1. When `mode_ext` is 0 it is `{0, fmt_value[6:5]}`, and bit 7 is ignored.
- R6: Code 0 gives `sample_enc`=0 (unsigned 8-bit) with `expand_sel`=0. Code 1 gives `sample_enc`=2 with `expand_sel`=1 (mu-law). Code 3 gives `sample_enc`=2 with `expand_sel`=2 (A-law). For all three, `frame_shift` is 1 for stereo and 0 for mono, and `big_endian` is 0.
- R7: Code 2 gives `sample_enc`=1 (linear signed 16-bit) with `big_endian`=0. Code 6 gives `sample_enc`=1 with `big_endian`=1. For both, `expand_sel`=0 and `frame_shift` is 2 for stereo and 1 for mono.
- R8: A strobe with code 4, 5 or 7, or with an illegal rate, sets `fmt_err` and clears `dma_hold` in the next cycle. The decoded outputs keep their values. `fmt_err` stays set until a legal strobe clears it.
- R9: When `play_en` is 1, `dma_hold` is 0 and no error is pending, `dma_hold` rises in the next cycle. A legal strobe gives the same result. `xfer_clr` pulses for exactly the cycle in which `dma_hold` rises.
- R10: When `play_en` is 0, `dma_hold` is 0 in the next cycle.
- R11: While `fmt_err` is set, `dma_hold` stays 0 whatever `play_en` is.
- R12: A legal strobe while `dma_hold` is 1 and `play_en` is 1 keeps `dma_hold` at 1 and gives no `xfer_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_valid | input | 1 | Strobe: accept `fmt_value` this cycle |
| fmt_value | input | 8 | Playback format value |
| mode_ext | input | 1 | Mode bit: widens the encoding code to 3 bits |
| play_en | input | 1 | Playback enable level |
| rate_sel | output | 4 | Crystal (bit 0) and rate index (bits 3:1) |
| stereo | output | 1 | Two channels when 1 |
| sample_enc | output | 2 | 0 unsigned 8-bit, 1 signed 16-bit, 2 expanded to signed 16-bit |
| expand_sel | output | 2 | 0 none, 1 mu-law, 2 A-law |
| big_endian | output | 1 | Big-endian 16-bit samples |
| frame_shift | output | 2 | log2 of bytes per frame |
| fmt_err | output | 1 | Last strobe carried an illegal format |
| dma_hold | output | 1 | DMA request held and output active |
| xfer_clr | output | 1 | One-cycle pulse to clear the transfer counter |

## Verification
The bench sweeps all 256 format values under both mode settings. This catches a design that decodes bit 7 in narrow mode, which would show reserved codes and big-endian output where the mode forbids them. It also catches a design that swaps the two shift rules, which would give byte-sized frames for 16-bit data. The bench sends rejected formats while playback is enabled, and the invalid crystal-0 rates as well. A design that updates its settings on a rejected value, or that re-arms the DMA request before a legal value arrives, would then differ from the model. The bench also strobes legal values while the request is already held. A design that pulses the counter clear again at that point would be caught.

// File: rtl/pbfmt_pkg.sv
package pbfmt_pkg;

    localparam int FMT_W  = 8;
    localparam int RATE_W = 4;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        ENC_U8      = 2'd0,
        ENC_S16     = 2'd1,
        ENC_S16_EXP = 2'd2
    } enc_e;

    typedef enum logic [1:0] {
        EXP_NONE  = 2'd0,
        EXP_MULAW = 2'd1,
        EXP_ALAW  = 2'd2
    } exp_e;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              stereo;
        enc_e              enc;
        exp_e              expand;
        logic              big_end;
        logic [1:0]        shift;
    } fmt_t;

    typedef struct packed {
        fmt_t fmt;
        logic err;
        logic hold;
        logic clr;
    } state_t;

endpackage

// File: rtl/pbfmt_rate_check.sv
module pbfmt_rate_check
    import pbfmt_pkg::*;
#(
    parameter logic [(1<<RATE_W)-1:0] VALID_MASK = 16'hFAFF
) (
    input  logic [RATE_W-1:0] rate,
    output logic              rate_ok
);
    localparam int N_RATES = 1 << RATE_W;

    logic [N_RATES-1:0] hit;

    for (genvar i = 0; i < N_RATES; i++) begin : g_rate
        assign hit[i] = (rate == RATE_W'(i)) && VALID_MASK[i];
    end

    assign rate_ok = |hit;
endmodule

// File: rtl/pbfmt_field_decode.sv
module pbfmt_field_decode
    import pbfmt_pkg::*;
#(
    parameter logic [(1<<RATE_W)-1:0] VALID_MASK = 16'hFAFF
) (
    input  logic [FMT_W-1:0] value,
    input  logic             mode_ext,
    output fmt_t             dec,
    output logic             bad
);
    logic [CODE_W-1:0] code;
    logic              rate_ok;
    logic              code_bad;

    pbfmt_rate_check #(.VALID_MASK(VALID_MASK)) u_rate (
        .rate    (value[RATE_W-1:0]),
        .rate_ok (rate_ok)
    );

    always_comb begin
        code = mode_ext ? value[7:5] : {1'b0, value[6:5]};

        dec.rate    = value[RATE_W-1:0];
        dec.stereo  = value[4];
        dec.enc     = ENC_U8;
        dec.expand  = EXP_NONE;
        dec.big_end = 1'b0;
        dec.shift   = {1'b0, value[4]};
        code_bad    = 1'b0;

        case (code)
            3'd0: dec.enc = ENC_U8;
            3'd1: begin
                dec.enc    = ENC_S16_EXP;
                dec.expand = EXP_MULAW;
            end
            3'd3: begin
                dec.enc    = ENC_S16_EXP;
                dec.expand = EXP_ALAW;
            end
            3'd2, 3'd6: begin
                dec.enc     = ENC_S16;
                dec.big_end = code[2];
                dec.shift   = value[4] ? 2'd2 : 2'd1;
            end
            default: code_bad = 1'b1;
        endcase

        bad = code_bad || !rate_ok;
    end
endmodule

// File: rtl/pbfmt_dma_next.sv
module pbfmt_dma_next (
    input  logic fmt_valid,
    input  logic fmt_bad,
    input  logic play_en,
    input  logic err_q,
    input  logic hold_q,
    output logic err_d,
    output logic hold_d,
    output logic clr_d
);
    always_comb begin
        if (fmt_valid) begin
            err_d  = fmt_bad;
            hold_d = play_en && !fmt_bad;
        end else begin
            err_d  = err_q;
            hold_d = play_en && (hold_q || !err_q);
        end
        clr_d = hold_d && !hold_q;
    end
endmodule

// File: rtl/pbfmt_dreq_ctrl.sv
module pbfmt_dreq_ctrl
    import pbfmt_pkg::*;
#(
    parameter logic [15:0] RATE_VALID_MASK = 16'hFAFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fmt_valid,
    input  logic [7:0] fmt_value,
    input  logic       mode_ext,
    input  logic       play_en,
    output logic [3:0] rate_sel,
    output logic       stereo,
    output logic [1:0] sample_enc,
    output logic [1:0] expand_sel,
    output logic       big_endian,
    output logic [1:0] frame_shift,
    output logic       fmt_err,
    output logic       dma_hold,
    output logic       xfer_clr
);
    localparam state_t RESET_STATE = '0;

    state_t st_d, st_q;
    fmt_t   dec;
    logic   bad;
    logic   err_d, hold_d, clr_d;

    pbfmt_field_decode #(.VALID_MASK(RATE_VALID_MASK)) u_dec (
        .value    (fmt_value),
        .mode_ext (mode_ext),
        .dec      (dec),
        .bad      (bad)
    );

    pbfmt_dma_next u_dma (
        .fmt_valid (fmt_valid),
        .fmt_bad   (bad),
        .play_en   (play_en),
        .err_q     (st_q.err),
        .hold_q    (st_q.hold),
        .err_d     (err_d),
        .hold_d    (hold_d),
        .clr_d     (clr_d)
    );

    always_comb begin
        st_d      = st_q;
        st_d.err  = err_d;
        st_d.hold = hold_d;
        st_d.clr  = clr_d;
        if (fmt_valid && !bad) begin
            st_d.fmt = dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign rate_sel    = st_q.fmt.rate;
    assign stereo      = st_q.fmt.stereo;
    assign sample_enc  = st_q.fmt.enc;
    assign expand_sel  = st_q.fmt.expand;
    assign big_endian  = st_q.fmt.big_end;
    assign frame_shift = st_q.fmt.shift;
    assign fmt_err     = st_q.err;
    assign dma_hold    = st_q.hold;
    assign xfer_clr    = st_q.clr;
endmodule

// File: rtl/pbfmt_dreq_ctrl_chk.sv
module pbfmt_dreq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fmt_valid,
    input logic [7:0] fmt_value,
    input logic       mode_ext,
    input logic       play_en,
    input logic [3:0] rate_sel,
    input logic       stereo,
    input logic [1:0] sample_enc,
    input logic [1:0] frame_shift,
    input logic       fmt_err,
    input logic       dma_hold,
    input logic       xfer_clr
);
    assert_hold_settings_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_valid |=> $stable(rate_sel) && $stable(stereo) && $stable(sample_enc)
                       && $stable(frame_shift));

    assert_linear_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_enc == 2'd1) |-> (frame_shift == (stereo ? 2'd2 : 2'd1)));

    assert_reserved_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_valid && mode_ext && (fmt_value[7:5] == 3'd4)) |=> (fmt_err && !dma_hold));

    assert_clr_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_clr |-> (dma_hold && !$past(dma_hold)));

    assert_disable_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !play_en |=> !dma_hold);

    assert_err_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> !dma_hold);
endmodule

bind pbfmt_dreq_ctrl pbfmt_dreq_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt_valid   (fmt_valid),
    .fmt_value   (fmt_value),
    .mode_ext    (mode_ext),
    .play_en     (play_en),
    .rate_sel    (rate_sel),
    .stereo      (stereo),
    .sample_enc  (sample_enc),
    .frame_shift (frame_shift),
    .fmt_err     (fmt_err),
    .dma_hold    (dma_hold),
    .xfer_clr    (xfer_clr)
);

// File: tb/tb_pbfmt_dreq_ctrl.sv
`timescale 1ns/1ps
module tb_pbfmt_dreq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fmt_valid = 1'b0;
    logic [7:0] fmt_value = 8'h00;
    logic       mode_ext = 1'b0;
    logic       play_en = 1'b0;
    logic [3:0] rate_sel;
    logic       stereo;
    logic [1:0] sample_enc;
    logic [1:0] expand_sel;
    logic       big_endian;
    logic [1:0] frame_shift;
    logic       fmt_err;
    logic       dma_hold;
    logic       xfer_clr;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // reference model state
    int m_rate = 0, m_st = 0, m_enc = 0, m_exp = 0, m_be = 0, m_sh = 0;
    int m_err = 0, m_hold = 0, m_clr = 0;

    always #2.5 clk = ~clk;

    pbfmt_dreq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .fmt_valid(fmt_valid), .fmt_value(fmt_value),
        .mode_ext(mode_ext), .play_en(play_en), .rate_sel(rate_sel), .stereo(stereo),
        .sample_enc(sample_enc), .expand_sel(expand_sel), .big_endian(big_endian),
        .frame_shift(frame_shift), .fmt_err(fmt_err), .dma_hold(dma_hold),
        .xfer_clr(xfer_clr)
    );

    task automatic chk(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural model, stepped on each rising edge
    always @(posedge clk) begin
        int code;
        bit bad;
        int old_hold;
        if (!rst_n) begin
            m_rate = 0; m_st = 0; m_enc = 0; m_exp = 0; m_be = 0; m_sh = 0;
            m_err = 0; m_hold = 0; m_clr = 0;
        end else begin
            old_hold = m_hold;
            if (fmt_valid) begin
                code = mode_ext ? int'(fmt_value[7:5]) : int'(fmt_value[6:5]);
                bad = (code == 4) || (code == 5) || (code == 7)
                      || (fmt_value[3:0] == 4'd8) || (fmt_value[3:0] == 4'd10);
                if (bad) begin
                    m_err = 1;
                    m_hold = 0;
                end else begin
                    m_err = 0;
                    m_hold = play_en ? 1 : 0;
                    m_rate = int'(fmt_value[3:0]);
                    m_st = int'(fmt_value[4]);
                    m_be = (code == 6) ? 1 : 0;
                    if (code == 2 || code == 6) begin
                        m_enc = 1; m_exp = 0; m_sh = m_st + 1;
                    end else begin
                        m_enc = (code == 0) ? 0 : 2;
                        m_exp = (code == 0) ? 0 : ((code == 1) ? 1 : 2);
                        m_sh = m_st;
                    end
                end
            end else begin
                m_hold = (play_en && (m_hold == 1 || m_err == 0)) ? 1 : 0;
            end
            m_clr = (m_hold == 1 && old_hold == 0) ? 1 : 0;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(rate_sel), m_rate, "R3", "rate_sel");
            chk(int'(stereo), m_st, "R4", "stereo");
            chk(int'(sample_enc), m_enc, "R5/R6", "sample_enc");
            chk(int'(expand_sel), m_exp, "R6", "expand_sel");
            chk(int'(big_endian), m_be, "R7", "big_endian");
            chk(int'(frame_shift), m_sh, "R6/R7", "frame_shift");
            chk(int'(fmt_err), m_err, "R8", "fmt_err");
            chk(int'(dma_hold), m_hold, "R9", "dma_hold");
            chk(int'(xfer_clr), m_clr, "R9", "xfer_clr");
        end
    end

    task automatic strobe(input logic [7:0] v, input logic m);
        @(negedge clk);
        fmt_valid = 1'b1; fmt_value = v; mode_ext = m;
        @(negedge clk);
        fmt_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(int'({rate_sel, stereo, sample_enc, expand_sel, big_endian, frame_shift}), 0, "R1", "settings");
        chk(int'({fmt_err, dma_hold, xfer_clr}), 0, "R1", "control");

        // R4 R6 stereo unsigned 8-bit
        strobe(8'h11, 1'b0);
        chk(int'(frame_shift), 1, "R6", "u8 stereo shift");
        chk(int'(stereo), 1, "R4", "stereo");
        // R5 bit 7 ignored in narrow mode: code 2
        strobe(8'hC1, 1'b0);
        chk(int'(sample_enc), 1, "R5", "narrow code");
        chk(int'(big_endian), 0, "R5", "narrow endian");
        // R7 wide mode same value: code 6
        strobe(8'hD1, 1'b1);
        chk(int'(big_endian), 1, "R7", "big endian");
        chk(int'(frame_shift), 2, "R7", "s16 stereo shift");
        // R8 reserved code keeps settings
        strobe(8'h81, 1'b1);
        chk(int'(fmt_err), 1, "R8", "err set");
        chk(int'(big_endian), 1, "R8", "settings kept");
        // R11 enable while in error
        play_en = 1'b1;
        repeat (4) @(negedge clk);
        chk(int'(dma_hold), 0, "R11", "hold blocked");
        // R9 legal strobe starts DMA
        strobe(8'h01, 1'b1);
        chk(int'(dma_hold), 1, "R9", "hold");
        chk(int'(xfer_clr), 1, "R9", "clr pulse");
        @(negedge clk);
        chk(int'(xfer_clr), 0, "R9", "clr one cycle");
        // R12 legal strobe while running
        strobe(8'h23, 1'b0);
        chk(int'(dma_hold), 1, "R12", "hold kept");
        chk(int'(xfer_clr), 0, "R12", "no pulse");
        chk(int'(expand_sel), 1, "R6", "mu-law");
        // R3 R8 illegal rate
        strobe(8'h08, 1'b0);
        chk(int'(fmt_err), 1, "R3", "illegal rate err");
        chk(int'(dma_hold), 0, "R8", "hold dropped");
        strobe(8'h6A, 1'b0);
        chk(int'(fmt_err), 1, "R3", "illegal rate 10");
        strobe(8'h62, 1'b0);
        chk(int'(expand_sel), 2, "R6", "A-law");
        chk(int'(dma_hold), 1, "R9", "restart");
        // R10 disable
        play_en = 1'b0;
        @(negedge clk);
        chk(int'(dma_hold), 0, "R10", "hold released");
        // R9 enable with no strobe and no error
        play_en = 1'b1;
        @(negedge clk);
        chk(int'(xfer_clr), 1, "R9", "enable pulse");

        // sweep, checked by the model every cycle (R2..R12)
        for (int m = 0; m < 2; m++) begin
            for (int v = 0; v < 256; v++) begin
                play_en = ($urandom % 4) != 0;
                strobe(8'(v), 1'(m));
                repeat ($urandom % 3) @(negedge clk);
            end
        end
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule